// File: doc/BRIEF.md
# Two-Profile Boot Image SPI Master

This block pushes a boot image, one 16-bit word at a time, into a processor that listens as an SPI slave. Every word is full duplex: while the master shifts its word out on MOSI it collects a word on MISO, and that word is handed back through a received-word output. The slave handles each word in software, so the master leaves a minimum quiet time between words, counted from the moment chip select is released.

Two timing profiles are built in, each a pair of SCLK half-period and idle-gap counts in system-clock cycles. The slow profile suits a slave that still runs on its reset clock (SCLK up to about 3 MHz, about 29 us between words). The fast profile suits the slave after it has set up its clock multiplier (SCLK up to about 11.5 MHz, about 2.3 us between words). A pulse on `go_fast` makes the switch. It takes effect from the next accepted word. Every half period is raised, where needed, to the smallest value that keeps SCLK at or below the 50 MHz ceiling of the slave interface.

Top module: `spi_boot_master`

## Requirements
- R1: While reset is held and in the first cycle after it, `cs_n` is 1, `sclk` is 0, `rx_valid` is 0 and `in_ready` is 1.
- R2: Each word is 16 bits in SPI mode 0, MSB first. SCLK idles low. MOSI changes only on a falling SCLK edge while chip select is active. The 16 bits seen by the slave on the 16 rising edges equal `in_data` of the accepted word.
- R3: `rx_data` holds the 16 MISO bits sampled on the 16 rising edges, MSB first. `rx_valid` is high for exactly one cycle per word, in the cycle that starts with the 16th rising edge.
- R4: Each word has exactly 32 SCLK edges. Every SCLK high time and low time inside a word equals the half period H of that word's profile, in system-clock cycles.
- R5: `cs_n` falls on the clock edge that accepts a word. The first rising SCLK edge comes H cycles later, and `cs_n` rises H cycles after the last falling edge.
- R6: `cs_n` stays high for at least G cycles between words, where G is the gap count of the profile of the word just finished. If `in_valid` is held high throughout, it stays high for exactly G+1 cycles.
- R7: `in_ready` is high only while no word is in progress and the gap has run out. It is low whenever `cs_n` is low.
- R8: A `go_fast` pulse is remembered until reset. A word already in progress, and the gap after it, keep the slow profile. Every word accepted afterwards uses the fast profile.
- R9: A configured half period below ceil(CLK_HZ / (2 * 50 MHz)) is raised to that value. With a 125 MHz clock this minimum is 2 cycles.
- R10: `in_valid` has no effect while `in_ready` is low. Exactly one word is framed for each handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Boot word offered |
| in_ready | output | 1 | Master can take a word |
| in_data | input | DATA_W | Word to shift out |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| rx_data | output | DATA_W | Word collected from MISO |
| go_fast | input | 1 | Pulse: slave clocks reconfigured, use fast profile |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Master data out |
| miso | input | 1 | Slave data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The assertions check, on every cycle, the behaviours that are properties of single cycles or edges. These are the low idle clock, MOSI changing only on falling edges, `in_ready` never overlapping an active chip select, chip select following each handshake, the single-cycle receive strobe, and the floor on every SCLK half period. Some behaviours can only be shown by the bench's scenarios, with a slave model and a cycle-counting monitor. These are the exact lead, half-period and trail widths of each profile, the gap length, and the serial data in both directions. The profile switch during a word in progress also needs a scenario: that word and the gap after it must stay slow while later words turn fast.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;

    localparam int HALF_W = 12;
    localparam int GAP_W  = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL
    } word_state_e;

    typedef struct packed {
        logic [HALF_W-1:0] half;
        logic [GAP_W-1:0]  gap;
    } profile_t;

    // Smallest half period (in clk cycles) keeping SCLK at or below max_hz.
    function automatic int half_floor(longint clk_hz, longint max_hz);
        return int'((clk_hz + 2 * max_hz - 1) / (2 * max_hz));
    endfunction

    function automatic int clamp_half(int want, int floor_cycles);
        int lo;
        lo = (floor_cycles < 1) ? 1 : floor_cycles;
        return (want < lo) ? lo : want;
    endfunction

endpackage

// File: rtl/spi_boot_profile.sv
module spi_boot_profile
    import spi_boot_pkg::*;
#(
    parameter int SLOW_HALF = 21,
    parameter int SLOW_GAP  = 3625,
    parameter int FAST_HALF = 6,
    parameter int FAST_GAP  = 288,
    parameter int MIN_HALF  = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     go_fast,
    output profile_t sel_prof
);
    localparam int SLOW_H = clamp_half(SLOW_HALF, MIN_HALF);
    localparam int FAST_H = clamp_half(FAST_HALF, MIN_HALF);

    localparam profile_t SLOW_P = '{half: HALF_W'(SLOW_H), gap: GAP_W'(SLOW_GAP)};
    localparam profile_t FAST_P = '{half: HALF_W'(FAST_H), gap: GAP_W'(FAST_GAP)};

    logic fast_q;

    always_ff @(posedge clk) begin
        if (rst)          fast_q <= 1'b0;
        else if (go_fast) fast_q <= 1'b1;
    end

    assign sel_prof = fast_q ? FAST_P : SLOW_P;
endmodule

// File: rtl/spi_boot_gap.sv
module spi_boot_gap
    import spi_boot_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [GAP_W-1:0] gap,
    output logic             expired
);
    logic [GAP_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)                left_q <= '0;
        else if (load)          left_q <= gap;
        else if (left_q != '0)  left_q <= left_q - 1'b1;
    end

    assign expired = (left_q == '0);
endmodule

// File: rtl/spi_boot_engine.sv
module spi_boot_engine
    import spi_boot_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [DATA_W-1:0] tx_data,
    input  profile_t          prof_in,
    input  logic              miso,
    output logic              idle,
    output logic              release_now,
    output logic [GAP_W-1:0]  word_gap,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data
);
    localparam int EDGES = 2 * DATA_W;
    localparam int TOG_W = $clog2(EDGES);
    localparam logic [TOG_W-1:0] LAST_TOG = TOG_W'(EDGES - 1);
    localparam logic [TOG_W-1:0] LAST_RISE_TOG = TOG_W'(EDGES - 2);

    word_state_e       state_q;
    profile_t          prof_q;
    logic [HALF_W-1:0] cnt_q;
    logic [TOG_W-1:0]  tog_q;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic              sclk_q;
    logic              cs_q;
    logic              rxv_q;

    logic tick, do_rise, do_fall, last_fall, rx_done;

    assign tick      = (cnt_q == '0);
    assign do_rise   = tick && ((state_q == ST_LEAD) || (state_q == ST_SHIFT && !sclk_q));
    assign do_fall   = tick && (state_q == ST_SHIFT) && sclk_q;
    assign last_fall = do_fall && (tog_q == LAST_TOG);
    assign rx_done   = do_rise && (tog_q == LAST_RISE_TOG);

    assign release_now = tick && (state_q == ST_TRAIL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            prof_q  <= '0;
            cnt_q   <= '0;
            tog_q   <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
            sclk_q  <= 1'b0;
            cs_q    <= 1'b1;
            rxv_q   <= 1'b0;
        end else begin
            rxv_q <= rx_done;
            if (state_q == ST_IDLE) begin
                if (accept) begin
                    state_q <= ST_LEAD;
                    cs_q    <= 1'b0;
                    tx_q    <= tx_data;
                    prof_q  <= prof_in;
                    cnt_q   <= prof_in.half - 1'b1;
                    tog_q   <= '0;
                end
            end else begin
                cnt_q <= tick ? prof_q.half - 1'b1 : cnt_q - 1'b1;
                if (do_rise) begin
                    sclk_q  <= 1'b1;
                    tog_q   <= tog_q + 1'b1;
                    rx_q    <= {rx_q[DATA_W-2:0], miso};
                    state_q <= ST_SHIFT;
                end
                if (do_fall) begin
                    sclk_q <= 1'b0;
                    tog_q  <= tog_q + 1'b1;
                    tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
                    if (last_fall) state_q <= ST_TRAIL;
                end
                if (release_now) begin
                    cs_q    <= 1'b1;
                    state_q <= ST_IDLE;
                end
            end
        end
    end

    assign idle     = (state_q == ST_IDLE);
    assign word_gap = prof_q.gap;
    assign sclk     = sclk_q;
    assign mosi     = tx_q[DATA_W-1];
    assign cs_n     = cs_q;
    assign rx_valid = rxv_q;
    assign rx_data  = rx_q;
endmodule

// File: rtl/spi_boot_master.sv
module spi_boot_master
    import spi_boot_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CLK_HZ      = 125_000_000,
    parameter int MAX_SCLK_HZ = 50_000_000,
    parameter int SLOW_HALF   = 21,
    parameter int SLOW_GAP    = 3625,
    parameter int FAST_HALF   = 6,
    parameter int FAST_GAP    = 288
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    input  logic              go_fast,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    localparam int MIN_H = half_floor(longint'(CLK_HZ), longint'(MAX_SCLK_HZ));

    profile_t         sel_prof;
    logic             idle, gap_done, accept, release_now;
    logic [GAP_W-1:0] word_gap;

    assign in_ready = idle && gap_done;
    assign accept   = in_valid && in_ready;

    spi_boot_profile #(
        .SLOW_HALF (SLOW_HALF),
        .SLOW_GAP  (SLOW_GAP),
        .FAST_HALF (FAST_HALF),
        .FAST_GAP  (FAST_GAP),
        .MIN_HALF  (MIN_H)
    ) u_profile (
        .clk      (clk),
        .rst      (rst),
        .go_fast  (go_fast),
        .sel_prof (sel_prof)
    );

    spi_boot_gap u_gap (
        .clk     (clk),
        .rst     (rst),
        .load    (release_now),
        .gap     (word_gap),
        .expired (gap_done)
    );

    spi_boot_engine #(
        .DATA_W (DATA_W)
    ) u_engine (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .tx_data     (in_data),
        .prof_in     (sel_prof),
        .miso        (miso),
        .idle        (idle),
        .release_now (release_now),
        .word_gap    (word_gap),
        .sclk        (sclk),
        .mosi        (mosi),
        .cs_n        (cs_n),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data)
    );
endmodule

// File: rtl/spi_boot_master_checker.sv
module spi_boot_master_checker
    import spi_boot_pkg::*;
#(
    parameter int CLK_HZ      = 125_000_000,
    parameter int MAX_SCLK_HZ = 50_000_000
) (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic sclk,
    input logic mosi,
    input logic cs_n,
    input logic rx_valid
);
    localparam int FLOOR = half_floor(longint'(CLK_HZ), longint'(MAX_SCLK_HZ));
    localparam int SINCE_W = HALF_W + 1;

    logic [SINCE_W-1:0] since_q;
    logic               sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= '1;
            sclk_d  <= 1'b0;
        end else begin
            sclk_d <= sclk;
            if (sclk != sclk_d)      since_q <= SINCE_W'(1);
            else if (since_q != '1)  since_q <= since_q + 1'b1;
        end
    end

    p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    p_mosi_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        (!$stable(mosi) && !cs_n && $past(!cs_n)) |-> $fell(sclk));

    p_ready_deselected_r7: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> cs_n);

    p_accept_selects_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !cs_n);

    p_rx_single_r3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    p_rx_in_high_r3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (sclk && !cs_n));

    p_half_floor_r9: assert property (@(posedge clk) disable iff (rst)
        (sclk != sclk_d) |-> (since_q >= SINCE_W'(FLOOR)));
endmodule

bind spi_boot_master spi_boot_master_checker #(
    .CLK_HZ      (CLK_HZ),
    .MAX_SCLK_HZ (MAX_SCLK_HZ)
) u_spi_boot_master_checker (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .sclk     (sclk),
    .mosi     (mosi),
    .cs_n     (cs_n),
    .rx_valid (rx_valid)
);

// File: tb/spi_boot_master_bench.sv
module spi_boot_master_bench;
    localparam int DATA_W    = 16;
    localparam int CLK_HZ    = 125_000_000;
    localparam int MAX_HZ    = 50_000_000;
    localparam int SLOW_HALF = 5;
    localparam int SLOW_GAP  = 37;
    localparam int FAST_HALF = 1;
    localparam int FAST_GAP  = 9;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              go_fast = 1'b0;
    logic              miso = 1'b0;
    logic              in_ready, rx_valid, sclk, mosi, cs_n;
    logic [DATA_W-1:0] rx_data;

    always #4 clk = ~clk;

    spi_boot_master #(
        .DATA_W (DATA_W), .CLK_HZ (CLK_HZ), .MAX_SCLK_HZ (MAX_HZ),
        .SLOW_HALF (SLOW_HALF), .SLOW_GAP (SLOW_GAP),
        .FAST_HALF (FAST_HALF), .FAST_GAP (FAST_GAP)
    ) u_spi_boot_master (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
        .in_data (in_data), .rx_valid (rx_valid), .rx_data (rx_data),
        .go_fast (go_fast), .sclk (sclk), .mosi (mosi), .miso (miso), .cs_n (cs_n)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    function automatic int exp_half(bit fast);
        int lo, h;
        lo = (CLK_HZ + 2 * MAX_HZ - 1) / (2 * MAX_HZ);
        h  = fast ? FAST_HALF : SLOW_HALF;
        return (h < lo) ? lo : h;
    endfunction

    function automatic int exp_gap(bit fast);
        return fast ? FAST_GAP : SLOW_GAP;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // expected stream for the monitor
    logic [DATA_W-1:0] tx_exp[$];
    bit                b2b_exp[$];
    bit                fast_req = 0;
    int                sent = 0;

    // monitor and slave model
    int unsigned       cyc = 0;
    logic              prev_cs = 1'b1, prev_sclk = 1'b0;
    int unsigned       t_last = 0, t_rise = 0;
    int                words = 0, fast_words = 0;
    int                lead = 0, togs = 0, rises = 0, rxv_n = 0, sbit = 0;
    bit                hbad = 0, ready_bad = 0, cur_fast = 0, prev_fast = 0, cur_b2b = 0;
    logic [DATA_W-1:0] slave_word = '0, mosi_cap = '0, cur_tx = '0;

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(0, "WATCHDOG", "run did not finish", int'(cyc), 150000);
            finish_run();
        end
        if (!rst) begin
            if (prev_cs && !cs_n) begin
                words++;
                cur_fast = fast_req;
                if (cur_fast) fast_words++;
                cur_tx  = (tx_exp.size() > 0) ? tx_exp.pop_front() : '0;
                cur_b2b = (b2b_exp.size() > 0) ? b2b_exp.pop_front() : 1'b0;
                if (words > 1) begin
                    if (cur_b2b)
                        chk(int'(cyc - t_rise) == exp_gap(prev_fast) + 1, "R6",
                            "gap with valid waiting", int'(cyc - t_rise), exp_gap(prev_fast) + 1);
                    else
                        chk(int'(cyc - t_rise) >= exp_gap(prev_fast), "R6",
                            "minimum gap", int'(cyc - t_rise), exp_gap(prev_fast));
                end
                slave_word = 16'($urandom);
                miso  = slave_word[DATA_W-1];
                sbit  = DATA_W - 2;
                t_last = cyc; togs = 0; rises = 0; rxv_n = 0;
                hbad = 0; ready_bad = 0; mosi_cap = '0;
            end else if (!cs_n) begin
                if (in_ready) ready_bad = 1;
                if (sclk != prev_sclk) begin
                    if (togs == 0) lead = int'(cyc - t_last);
                    else if (int'(cyc - t_last) != exp_half(cur_fast)) hbad = 1;
                    t_last = cyc;
                    togs++;
                    if (sclk) begin
                        mosi_cap = {mosi_cap[DATA_W-2:0], mosi};
                        rises++;
                    end else if (sbit >= 0) begin
                        miso = slave_word[sbit];
                        sbit--;
                    end
                end
                if (rx_valid) begin
                    rxv_n++;
                    chk(rises == DATA_W, "R3", "strobe after 16th rise", rises, DATA_W);
                    chk(rx_data == slave_word, "R3", "received word", rx_data, slave_word);
                end
            end else if (!prev_cs && cs_n) begin
                // R4 R5 R2 R7 R8 R9 per word
                chk(lead == exp_half(cur_fast), cur_fast ? "R9" : "R5", "lead cycles", lead, exp_half(cur_fast));
                chk(!hbad, cur_fast ? "R8" : "R4", "half period", int'(hbad), 0);
                chk(togs == 2 * DATA_W, "R4", "edge count", togs, 2 * DATA_W);
                chk(int'(cyc - t_last) == exp_half(cur_fast), "R5", "trail cycles",
                    int'(cyc - t_last), exp_half(cur_fast));
                chk(mosi_cap == cur_tx, "R2", "word on MOSI", mosi_cap, cur_tx);
                chk(rxv_n == 1, "R3", "strobe count", rxv_n, 1);
                chk(!ready_bad, "R7", "ready while selected", int'(ready_bad), 0);
                t_rise = cyc;
                prev_fast = cur_fast;
            end
        end
        prev_cs   = cs_n;
        prev_sclk = sclk;
    end

    task automatic send(logic [DATA_W-1:0] d, bit b2b);
        in_valid = 1'b1;
        in_data  = d;
        while (!in_ready) @(negedge clk);
        tx_exp.push_back(d);
        b2b_exp.push_back(b2b);
        sent++;
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = ~d;
    endtask

    task automatic pause(bit b2b);
        if (!b2b) repeat ($urandom_range(1, 50)) @(negedge clk);
    endtask

    initial begin
        logic [DATA_W-1:0] dir_slow[4];
        logic [DATA_W-1:0] dir_fast[3];
        void'($urandom(32'd4242));
        dir_slow = '{16'h0000, 16'hFFFF, 16'h8001, 16'hA5A5};
        dir_fast = '{16'h7FFE, 16'h0001, 16'hC33C};

        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R1", "pins during reset", {cs_n, sclk}, 2'b10);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n == 1'b1, "R1", "cs_n after reset", cs_n, 1);
        chk(sclk == 1'b0, "R1", "sclk after reset", sclk, 0);
        chk(rx_valid == 1'b0, "R1", "rx_valid after reset", rx_valid, 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

        // slow profile: directed then random, mixed pacing
        for (int i = 0; i < 4; i++) begin
            bit b = (i % 2) == 0;
            send(dir_slow[i], b);
            pause(i % 2 == 1 ? 1'b1 : 1'b0);
        end
        for (int i = 0; i < 3; i++) begin
            bit b = 1'($urandom % 2);
            send(16'($urandom), b);
            pause(b);
        end

        // R8: switch requested while a slow word is in flight
        send(16'h5AA5, 1'b1);
        repeat (3) @(negedge clk);
        go_fast  = 1'b1;
        fast_req = 1'b1;
        @(negedge clk);
        go_fast = 1'b0;

        // fast profile (R9: configured half of 1 is raised)
        for (int i = 0; i < 3; i++) begin
            send(dir_fast[i], 1'b1);
        end
        for (int i = 0; i < 10; i++) begin
            bit b = 1'($urandom % 2);
            send(16'($urandom), b);
            pause(b);
        end

        while (!cs_n) @(negedge clk);
        repeat (100) @(negedge clk);
        chk(words == sent, "R10", "words framed per handshake", words, sent);
        chk(fast_words == 13, "R8", "words in fast profile", fast_words, 13);
        chk(in_ready == 1'b1, "R7", "ready after final gap", in_ready, 1);
        finish_run();
    end
endmodule